// File: doc/BRIEF.md
# Programmable Square-Wave Output Generator

This block turns a 32.768 kHz clock enable into one of four selectable square waves, or into a fixed logic level, on a single open-drain output. A free-running binary divider counts the enable pulses; three of its bits serve as rate taps, and the enable itself serves as the fastest rate. The same divider marks the end of each second with a one-cycle tick for the timekeeping logic nearby, so the 1 Hz wave and the seconds count always share a phase.

An 8-bit control register holds three fields: a static level, a wave enable and a 2-bit rate select. When the wave is disabled, the static level drives the pin. A clear input, pulsed by the owner of the seconds register whenever that register is written, zeroes the divider so that the next second and the 1 Hz wave both restart from that moment.

Top module: `sqwave_gen`

## Requirements
- R1: The control register reads back the last value written, masked with 8'h93: bit 7 is the static level, bit 4 is the wave enable, bits 1:0 are the rate select, and every other bit reads as 0.
- R2: After reset the control register reads 8'h80, the divider is zero, the pin is released and `sec_tick` is low.
- R3: With the enable set, rate 2'b00 gives divider bit 14 (period 32768 enables), rate 2'b01 gives divider bit 2 (period 8 enables) and rate 2'b10 gives divider bit 1 (period 4 enables), each low for the first half of its period.
- R4: With the enable set and rate 2'b11, the level is high in exactly the cycles that follow a cycle with `tick_in` high and `div_clear` low.
- R5: With the enable clear, the level equals control bit 7 whatever the rate select, `tick_in` and `div_clear` do.
- R6: The pin is open drain: `sq_drive_low` is the inverse of the selected level, so a high level releases the pin.
- R7: `sec_tick` is high for one cycle, in the cycle after the enable that wraps the divider from all ones to zero; at that moment the 1 Hz wave is low, so the tick lines up with its falling edge.
- R8: `div_clear` zeroes the divider in the next cycle, takes precedence over `tick_in`, and suppresses `sec_tick` and the fastest-rate pulse for that cycle.
- R9: The divider, and with it every divided rate and `sec_tick`, advances only in cycles with `tick_in` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | 32.768 kHz clock enable, one cycle per oscillator period |
| div_clear | input | 1 | Zeroes the divider (seconds register written) |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register contents, reserved bits zero |
| sq_drive_low | output | 1 | Open-drain pull-down request; 0 releases the pin |
| sec_tick | output | 1 | One-cycle pulse at each second boundary |

## Verification
The hardest situation to reach is the divider wrap, which takes 32768 enables before the 1 Hz wave falls and the second tick appears. The bench drives the enable in every cycle for more than two full seconds of divider time, compares the wave and the tick against its own counter in every cycle, then clears the divider just before a wrap to show the tick is withheld and the phase restarts. Sparse enable patterns and enables coinciding with clears cover the ordering between the two inputs.

// File: rtl/sqwave_gen.sv
module sqwave_gen #(
  parameter int          DIV_W    = 15,
  parameter logic [7:0]  RST_CTRL = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_in,
  input  logic       div_clear,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  output logic [7:0] ctrl_rdata,
  output logic       sq_drive_low,
  output logic       sec_tick
);
  localparam logic [7:0]       CTRL_MASK = 8'h93;
  localparam int               SLOW_BIT  = DIV_W - 1;
  localparam int               MID_BIT   = 2;
  localparam int               FAST_BIT  = 1;
  localparam logic [DIV_W-1:0] CNT_LAST  = '1;

  logic [DIV_W-1:0] cnt;
  logic [7:0]       ctrl_q;
  logic             tick_q, sec_q, tap, level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      ctrl_q <= RST_CTRL & CTRL_MASK;
      tick_q <= 1'b0;
      sec_q  <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wdata & CTRL_MASK;
      tick_q <= tick_in & ~div_clear;
      sec_q  <= tick_in & ~div_clear & (cnt == CNT_LAST);
      if (div_clear)    cnt <= '0;
      else if (tick_in) cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    case (ctrl_q[1:0])
      2'b00:   tap = cnt[SLOW_BIT];
      2'b01:   tap = cnt[MID_BIT];
      2'b10:   tap = cnt[FAST_BIT];
      default: tap = tick_q;
    endcase
  end

  assign level        = ctrl_q[4] ? tap : ctrl_q[7];
  assign sq_drive_low = ~level;
  assign ctrl_rdata   = ctrl_q;
  assign sec_tick     = sec_q;
endmodule

// File: rtl/sqwave_gen_chk.sv
module sqwave_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_in,
  input logic       div_clear,
  input logic       ctrl_we,
  input logic [7:0] ctrl_rdata,
  input logic       sq_drive_low,
  input logic       sec_tick
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata & 8'h6C) == 8'h00);

  a_r5_static_level: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[4] |-> (sq_drive_low == !ctrl_rdata[7]));

  a_r7_tick_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && ctrl_rdata[4] && ctrl_rdata[1:0] == 2'b00) |-> sq_drive_low);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  a_r8_clear_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    div_clear |=> !sec_tick);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_in && !div_clear && !ctrl_we && ctrl_rdata[1:0] != 2'b11)
      |=> $stable(sq_drive_low));
endmodule

bind sqwave_gen sqwave_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .div_clear(div_clear),
  .ctrl_we(ctrl_we), .ctrl_rdata(ctrl_rdata),
  .sq_drive_low(sq_drive_low), .sec_tick(sec_tick)
);

// File: tb/sqwave_gen_bench.sv
module sqwave_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 15;
  localparam int DIV_MOD    = 1 << DIV_W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_in = 1'b0, div_clear = 1'b0, ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic [7:0] ctrl_rdata;
  logic       sq_drive_low, sec_tick;

  int checks = 0, failures = 0;
  int m_cnt = 0;
  logic [7:0] m_ctrl = 8'h80;
  logic m_tq = 1'b0, m_sec = 1'b0;
  int sec_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sqwave_gen #(.DIV_W(DIV_W)) u_sqwave_gen (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .div_clear(div_clear),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .sq_drive_low(sq_drive_low), .sec_tick(sec_tick)
  );

  function automatic logic exp_level();
    logic tap;
    case (m_ctrl[1:0])
      2'b00:   tap = m_cnt[DIV_W-1];
      2'b01:   tap = m_cnt[2];
      2'b10:   tap = m_cnt[1];
      default: tap = m_tq;
    endcase
    return m_ctrl[4] ? tap : m_ctrl[7];
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, ctrl_rdata, m_ctrl);
    check(req, sq_drive_low, !exp_level());
    check(req, sec_tick, m_sec);
  endtask

  task automatic step(logic t, logic c, logic we, logic [7:0] wd, string req);
    tick_in = t; div_clear = c; ctrl_we = we; ctrl_wdata = wd;
    @(posedge clk);
    if (we) m_ctrl = wd & 8'h93;
    m_tq  = t & ~c;
    m_sec = t & ~c & (m_cnt == DIV_MOD - 1);
    if (c) m_cnt = 0;
    else if (t) m_cnt = (m_cnt + 1) % DIV_MOD;
    if (m_sec) sec_seen++;
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R2 reset ctrl", ctrl_rdata, 8'h80);
    check("R2 reset pin released", sq_drive_low, 0);
    check("R2 reset tick", sec_tick, 0);

    // R1: every write value, no ticks
    for (int w = 0; w < 256; w++) step(1'b0, 1'b0, 1'b1, 8'(w), "R1 readback");

    // R3/R4/R6: each rate with wave enabled, enable every cycle
    for (int r = 0; r < 4; r++) begin
      step(1'b0, 1'b1, 1'b1, 8'h10 | 8'(r), "R3 rate select");
      for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0, 8'h00, "R3 R4 R6 rate wave");
      for (int i = 0; i < 40; i++) step(1'(i % 3 == 0), 1'b0, 1'b0, 8'h00, "R4 R9 sparse enable");
    end

    // R5: static level, every rate, with ticks and clears
    for (int v = 0; v < 8; v++) begin
      step(1'b0, 1'b0, 1'b1, ((v & 4) ? 8'h80 : 8'h00) | 8'h6C | 8'(v & 3), "R5 static write");
      for (int i = 0; i < 20; i++) step(1'(i % 2), 1'(i == 7), 1'b0, 8'h00, "R5 static level");
    end

    // R8: clear beats enable
    step(1'b0, 1'b0, 1'b1, 8'h11, "R8 setup");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0, 8'h00, "R8 pre");
    step(1'b1, 1'b1, 1'b0, 8'h00, "R8 clear with enable");
    check("R8 counter zero pin low", sq_drive_low, 1);

    // R7: 1 Hz wave across two wraps
    step(1'b0, 1'b1, 1'b1, 8'h10, "R7 setup");
    for (int i = 0; i < 2 * DIV_MOD + 100; i++) step(1'b1, 1'b0, 1'b0, 8'h00, "R3 R7 slow wave");
    check("R7 ticks seen", sec_seen, 2);

    // R8: clear right before a wrap withholds the tick and restarts phase
    while (m_cnt != DIV_MOD - 1) step(1'b1, 1'b0, 1'b0, 8'h00, "R8 approach");
    step(1'b1, 1'b1, 1'b0, 8'h00, "R8 clear at wrap");
    check("R8 no tick", sec_tick, 0);
    for (int i = 0; i < DIV_MOD / 2 + 10; i++) step(1'b1, 1'b0, 1'b0, 8'h00, "R8 R7 restarted phase");

    // R9: no enable, wave holds
    step(1'b0, 1'b0, 1'b1, 8'h12, "R9 setup");
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0, 1'b0, 8'h00, "R9 hold");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule